// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small 8-bit processor core. It combines the accumulator value with a second operand under a 4-bit operation code, and produces the new accumulator value, a write strobe for the accumulator and the next state of the four condition flags: zero, subtract, half-carry and carry. The block is purely combinational. The surrounding core reads the operands and the current flags, applies the outputs in the same cycle, and keeps all register, memory and sequencing state itself.

Each operation has its own rule for each flag. A flag that an operation does not define leaves the block with the same value it came in with. The add and subtract paths share one adder. Increment and decrement also run through that adder, with a fixed operand of one. Decimal adjust reads the incoming subtract, half-carry and carry flags to decide how to correct a packed-BCD accumulator after an earlier add or subtract.

Top module: `acc_alu`

## Requirements
- R1: The flag vector is {Z,N,H,C} with Z at bit 3 and C at bit 0. Operation codes: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 increment, 9 decrement, 10 complement, 11 set-carry, 12 complement-carry, 13 decimal adjust, 14 and 15 reserved. Add (0) and add-with-carry (1, carry-in = incoming C) produce A+B+cin. They set Z when the 8-bit result is zero, clear N, set H on a carry out of the low nibble (cin included) and set C on a carry out of bit 7. Both assert the write strobe.
- R2: Subtract (2) and subtract-with-borrow (3, borrow-in = incoming C) produce A-B-cin. They set N, set Z from the result, set H when the low nibble of B plus cin exceeds the low nibble of A, and set C when B plus cin exceeds A. Both assert the write strobe.
- R3: Compare (4) produces the same result and flags as subtract with a borrow-in of zero, and holds the write strobe low.
- R4: AND (5) outputs A&B, sets Z from the result, sets H, clears N and C, and asserts the write strobe.
- R5: OR (6) and XOR (7) output A|B and A^B, set Z from the result, clear N, H and C, and assert the write strobe.
- R6: Increment (8) and decrement (9) output A+1 and A-1 with wrap-around, and set Z from the result. Increment clears N and sets H when the low nibble of A is 0xF. Decrement sets N and sets H when the low nibble of A is 0x0. Both keep C and assert the write strobe.
- R7: Complement (10) outputs ~A, sets N and H, keeps Z and C, and asserts the write strobe.
- R8: Set-carry (11) forces C to 1 and complement-carry (12) inverts C. Both clear N and H, keep Z, output A unchanged and hold the write strobe low.
- R9: Decimal adjust (13) with incoming N=0 adds 0x06 when H is set or the low nibble of A exceeds 9. It adds 0x60 and sets C when C is set or A exceeds 0x99; otherwise C is cleared.
- R10: Decimal adjust with incoming N=1 subtracts 0x06 when H is set and 0x60 when C is set, and keeps C. In both directions decimal adjust keeps N, clears H, sets Z from the result and asserts the write strobe.
- R11: Reserved codes 14 and 15 output A unchanged, hold the write strobe low and pass all four flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| result_o | output | 8 | Operation result |
| wr_en_o | output | 1 | Write strobe for the accumulator |
| flags_o | output | 4 | Next flags {Z,N,H,C} |

## Verification
The hardest cases to reach are the decimal-adjust corrections, because they depend on flag combinations that only an earlier BCD add or subtract would normally leave behind. An accumulator above 0x99 with H set, or N=1 with both H and C set, rarely shows up when operands are drawn at random. The stimulus therefore drives the flags input directly with every combination around nibble boundaries. It mixes these with random vectors whose operands are biased toward 0x00, 0x0F, 0x99 and 0xFF, so that the half-carry and borrow edges occur often.

// File: rtl/acc_alu_pkg.sv
// Package: shared operation codes, flag layout and widths for the accumulator ALU.
// Assumes the flag vector is packed {Z,N,H,C} with Z in the top bit.
package acc_alu_pkg;
    localparam int DATA_W = 8;
    localparam int OP_W   = 4;
    localparam int FLAG_W = 4;

    localparam int FZ = 3;
    localparam int FN = 2;
    localparam int FH = 1;
    localparam int FC = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_CMP  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_INC  = 4'd8,
        OP_DEC  = 4'd9,
        OP_CPL  = 4'd10,
        OP_SCF  = 4'd11,
        OP_CCF  = 4'd12,
        OP_DAA  = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flag_s;
endpackage

// File: rtl/acc_alu_addsub.sv
// Module: shared adder/subtractor with nibble carry.
// Computes a +/- b +/- cin. On subtract, half and carry report borrows.
// Assumes W is even so that the half-carry nibble is W/2 bits wide.
module acc_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         half_o,
    output logic         carry_o
);
    localparam int HW = W / 2;

    logic [HW:0] lo_add;
    logic [HW:0] lo_sub;
    logic [W:0]  full_add;
    logic [W:0]  full_sub;

    // Both directions in parallel, each one bit wider to catch the carry.
    always_comb begin
        lo_add   = {1'b0, a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]} + {{HW{1'b0}}, cin_i};
        lo_sub   = {1'b0, a_i[HW-1:0]} - {1'b0, b_i[HW-1:0]} - {{HW{1'b0}}, cin_i};
        full_add = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        full_sub = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
    end

    // Pick the direction and take the top bits as carry or borrow.
    always_comb begin
        if (sub_i) begin
            sum_o   = full_sub[W-1:0];
            half_o  = lo_sub[HW];
            carry_o = full_sub[W];
        end else begin
            sum_o   = full_add[W-1:0];
            half_o  = lo_add[HW];
            carry_o = full_add[W];
        end
    end
endmodule

// File: rtl/acc_alu_logic.sv
// Module: bitwise unit. Computes AND, OR, XOR of two operands and the complement of the first.
// Assumes the caller selects among the outputs; no flag logic lives here.
module acc_alu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] xor_o,
    output logic [W-1:0] not_o
);
    // Per-bit gates, one generate lane per bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign and_o[i] = a_i[i] & b_i[i];
        assign or_o[i]  = a_i[i] | b_i[i];
        assign xor_o[i] = a_i[i] ^ b_i[i];
        assign not_o[i] = ~a_i[i];
    end
endmodule

// File: rtl/acc_alu_bcd.sv
// Module: packed-BCD decimal adjust of an 8-bit accumulator.
// Uses the incoming N, H and C flags to pick the add or subtract correction.
// Assumes the accumulator holds the raw binary result of a BCD add or subtract.
module acc_alu_bcd (
    input  logic [7:0] a_i,
    input  logic       n_i,
    input  logic       h_i,
    input  logic       c_i,
    output logic [7:0] res_o,
    output logic       c_o
);
    logic       lo_fix;
    logic       hi_fix;
    logic [7:0] corr;

    // Decide which nibbles need correction in each direction.
    always_comb begin
        if (n_i) begin
            lo_fix = h_i;
            hi_fix = c_i;
        end else begin
            lo_fix = h_i || (a_i[3:0] > 4'd9);
            hi_fix = c_i || (a_i > 8'h99);
        end
        corr = {1'b0, hi_fix, hi_fix, 1'b0, 1'b0, lo_fix, lo_fix, 1'b0};
    end

    // Apply the correction and form the new carry.
    always_comb begin
        if (n_i) begin
            res_o = a_i - corr;
            c_o   = c_i;
        end else begin
            res_o = a_i + corr;
            c_o   = hi_fix;
        end
    end
endmodule

// File: rtl/acc_alu.sv
// Module: 8-bit accumulator ALU with Z/N/H/C flags (top).
// Purely combinational. Selects one of the arithmetic, bitwise or BCD units and forms
// the result, the accumulator write strobe and the next flags. A flag an operation
// does not define is passed through. Assumes the caller registers the outputs.
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [FLAG_W-1:0] flags_o
);
    alu_op_e             op;
    flag_s               fin;
    flag_s               fout;
    logic [DATA_W-1:0]   as_b;
    logic                as_cin;
    logic                as_sub;
    logic [DATA_W-1:0]   as_sum;
    logic                as_half;
    logic                as_carry;
    logic [DATA_W-1:0]   lg_and;
    logic [DATA_W-1:0]   lg_or;
    logic [DATA_W-1:0]   lg_xor;
    logic [DATA_W-1:0]   lg_not;
    logic [7:0]          bcd_res;
    logic                bcd_c;

    assign op  = alu_op_e'(op_i);
    assign fin = flag_s'(flags_i);

    // Steer the shared adder's operand, carry-in and direction from the opcode.
    always_comb begin
        as_b   = opnd_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC:          as_cin = fin.c;
            OP_SUB, OP_CMP:  as_sub = 1'b1;
            OP_SBC: begin
                as_sub = 1'b1;
                as_cin = fin.c;
            end
            OP_INC:          as_b = DATA_W'(1);
            OP_DEC: begin
                as_b   = DATA_W'(1);
                as_sub = 1'b1;
            end
            default: ;
        endcase
    end

    acc_alu_addsub #(.W(DATA_W)) u_addsub (
        .a_i     (acc_i),
        .b_i     (as_b),
        .cin_i   (as_cin),
        .sub_i   (as_sub),
        .sum_o   (as_sum),
        .half_o  (as_half),
        .carry_o (as_carry)
    );

    acc_alu_logic #(.W(DATA_W)) u_logic (
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .and_o (lg_and),
        .or_o  (lg_or),
        .xor_o (lg_xor),
        .not_o (lg_not)
    );

    acc_alu_bcd u_bcd (
        .a_i   (acc_i[7:0]),
        .n_i   (fin.n),
        .h_i   (fin.h),
        .c_i   (fin.c),
        .res_o (bcd_res),
        .c_o   (bcd_c)
    );

    // Select the result, write strobe and per-operation flag pattern.
    always_comb begin
        result_o = acc_i;
        wr_en_o  = 1'b0;
        fout     = fin;
        unique case (op)
            OP_ADD, OP_ADC: begin
                result_o = as_sum;
                wr_en_o  = 1'b1;
                fout.n   = 1'b0;
                fout.h   = as_half;
                fout.c   = as_carry;
            end
            OP_SUB, OP_SBC, OP_CMP: begin
                result_o = as_sum;
                wr_en_o  = (op != OP_CMP);
                fout.n   = 1'b1;
                fout.h   = as_half;
                fout.c   = as_carry;
            end
            OP_AND: begin
                result_o = lg_and;
                wr_en_o  = 1'b1;
                fout.n   = 1'b0;
                fout.h   = 1'b1;
                fout.c   = 1'b0;
            end
            OP_OR, OP_XOR: begin
                result_o = (op == OP_OR) ? lg_or : lg_xor;
                wr_en_o  = 1'b1;
                fout.n   = 1'b0;
                fout.h   = 1'b0;
                fout.c   = 1'b0;
            end
            OP_INC, OP_DEC: begin
                result_o = as_sum;
                wr_en_o  = 1'b1;
                fout.n   = (op == OP_DEC);
                fout.h   = as_half;
            end
            OP_CPL: begin
                result_o = lg_not;
                wr_en_o  = 1'b1;
                fout.n   = 1'b1;
                fout.h   = 1'b1;
            end
            OP_SCF, OP_CCF: begin
                fout.n   = 1'b0;
                fout.h   = 1'b0;
                fout.c   = (op == OP_SCF) ? 1'b1 : ~fin.c;
            end
            OP_DAA: begin
                result_o = bcd_res;
                wr_en_o  = 1'b1;
                fout.h   = 1'b0;
                fout.c   = bcd_c;
            end
            default: ;
        endcase
    end

    // Zero flag follows the result for every operation that defines it.
    always_comb begin
        flags_o = fout;
        unique case (op)
            OP_CPL, OP_SCF, OP_CCF, OP_RSV0, OP_RSV1: ;
            default: flags_o[FZ] = (result_o == '0);
        endcase
    end
endmodule

// File: rtl/acc_alu_chk.sv
// Module: property checker for the accumulator ALU, attached by bind.
// Immediate assertions only, since the block has no clock.
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] acc_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_en_o,
    input logic [FLAG_W-1:0] flags_o
);
    // Check the output relations whenever the inputs settle.
    always_comb begin
        if (!$isunknown({op_i, acc_i, flags_i})) begin
            // R3
            cmp_no_write_chk: assert (op_i != OP_CMP || !wr_en_o)
                else $error("compare asserted write strobe");
            // R2
            sub_sets_n_chk: assert (!(op_i inside {OP_SUB, OP_SBC, OP_CMP}) || flags_o[FN])
                else $error("subtract family left N clear");
            // R5
            logic_clear_c_chk: assert (!(op_i inside {OP_AND, OP_OR, OP_XOR})
                                       || (!flags_o[FC] && flags_o[FZ] == (result_o == '0)))
                else $error("bitwise op carry or zero wrong");
            // R6
            incdec_keep_c_chk: assert (!(op_i inside {OP_INC, OP_DEC}) || flags_o[FC] == flags_i[FC])
                else $error("inc/dec changed carry");
            // R7
            cpl_keep_zc_chk: assert (op_i != OP_CPL
                                     || (flags_o[FZ] == flags_i[FZ] && flags_o[FC] == flags_i[FC]))
                else $error("complement changed Z or C");
            // R10
            daa_h_clear_chk: assert (op_i != OP_DAA || (!flags_o[FH] && flags_o[FN] == flags_i[FN]))
                else $error("decimal adjust H or N wrong");
            // R11
            rsvd_hold_chk: assert (!(op_i inside {OP_RSV0, OP_RSV1})
                                   || (flags_o == flags_i && !wr_en_o && result_o == acc_i))
                else $error("reserved code changed state");
        end
    end
endmodule

bind acc_alu acc_alu_chk u_chk (
    .op_i     (op_i),
    .acc_i    (acc_i),
    .flags_i  (flags_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .flags_o  (flags_o)
);

// File: tb/acc_alu_bench.sv
// Bench: directed corner vectors plus seeded random vectors, each compared with a bench reference model.
module acc_alu_bench;
    logic       clk;
    logic       rst_n;
    logic [3:0] op;
    logic [7:0] acc;
    logic [7:0] opnd;
    logic [3:0] fl;
    logic [7:0] res;
    logic       we;
    logic [3:0] fo;
    int         n_run;
    int         n_fail;
    bit         done;

    acc_alu u_acc_alu (
        .op_i     (op),
        .acc_i    (acc),
        .opnd_i   (opnd),
        .flags_i  (fl),
        .result_o (res),
        .wr_en_o  (we),
        .flags_o  (fo)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Requirement tag that covers a given operation code.
    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0, 4'd1:  return "R1";
            4'd2, 4'd3:  return "R2";
            4'd4:        return "R3";
            4'd5:        return "R4";
            4'd6, 4'd7:  return "R5";
            4'd8, 4'd9:  return "R6";
            4'd10:       return "R7";
            4'd11, 4'd12: return "R8";
            4'd13:       return "R9/R10";
            default:     return "R11";
        endcase
    endfunction

    // Reference model built from the requirements: returns {result, we, Z, N, H, C}.
    function automatic logic [12:0] ref_model(input logic [3:0] o, input logic [7:0] a,
                                              input logic [7:0] b, input logic [3:0] f);
        int  ai, bi, ci, t, adj;
        logic z, n, h, c, w;
        logic [7:0] r;
        ai = int'(a); bi = int'(b);
        z = f[3]; n = f[2]; h = f[1]; c = f[0];
        r = a; w = 1'b0;
        case (o)
            4'd0, 4'd1: begin
                ci = (o == 4'd1 && c) ? 1 : 0;
                t = ai + bi + ci; r = t[7:0];
                h = ((ai % 16) + (bi % 16) + ci) > 15; c = t > 255; n = 0; z = (r == 0); w = 1;
            end
            4'd2, 4'd3, 4'd4: begin
                ci = (o == 4'd3 && c) ? 1 : 0;
                t = ai - bi - ci; r = t[7:0];
                h = (ai % 16) < (bi % 16) + ci; c = (bi + ci) > ai; n = 1; z = (r == 0);
                w = (o != 4'd4);
            end
            4'd5: begin r = a & b; z = (r == 0); n = 0; h = 1; c = 0; w = 1; end
            4'd6: begin r = a | b; z = (r == 0); n = 0; h = 0; c = 0; w = 1; end
            4'd7: begin r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; w = 1; end
            4'd8: begin t = ai + 1; r = t[7:0]; z = (r == 0); n = 0; h = (ai % 16) == 15; w = 1; end
            4'd9: begin t = ai - 1; r = t[7:0]; z = (r == 0); n = 1; h = (ai % 16) == 0; w = 1; end
            4'd10: begin r = ~a; n = 1; h = 1; w = 1; end
            4'd11: begin n = 0; h = 0; c = 1; end
            4'd12: begin n = 0; h = 0; c = ~c; end
            4'd13: begin
                adj = 0;
                if (!n) begin
                    if (h || (ai % 16) > 9) adj += 6;
                    if (c || ai > 153) begin adj += 96; c = 1; end else c = 0;
                    t = ai + adj;
                end else begin
                    if (h) adj += 6;
                    if (c) adj += 96;
                    t = ai - adj;
                end
                r = t[7:0]; z = (r == 0); h = 0; w = 1;
            end
            default: ;
        endcase
        return {r, w, z, n, h, c};
    endfunction

    // Apply one vector on the falling edge, sample mid-cycle and compare.
    task automatic run_vec(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                           input logic [3:0] f, input string note);
        logic [12:0] exp_v;
        @(negedge clk);
        op = o; acc = a; opnd = b; fl = f;
        #2;
        exp_v = ref_model(o, a, b, f);
        n_run++;
        if ({res, we, fo} !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s op=%0d a=%02h b=%02h f=%b: got res=%02h we=%b fl=%b, exp res=%02h we=%b fl=%b",
                     tag_of(o), note, o, a, b, f, res, we, fo, exp_v[12:5], exp_v[4], exp_v[3:0]);
        end
    endtask

    // Pick a random byte biased toward nibble and BCD edges.
    function automatic logic [7:0] pick_byte();
        int k;
        k = $urandom_range(0, 7);
        case (k)
            0: return 8'h00;
            1: return 8'h0F;
            2: return 8'h99;
            3: return 8'hFF;
            default: return 8'($urandom);
        endcase
    endfunction

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Main sequence: reset, directed corners, then random vectors.
    initial begin
        void'($urandom(32'h1c5a));
        n_run = 0; n_fail = 0; done = 0;
        rst_n = 1'b0; op = 4'd14; acc = 8'h5A; opnd = 8'h00; fl = 4'b1010;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R11 idle state after reset: reserved code passes everything through
        run_vec(4'd14, 8'h5A, 8'h00, 4'b1010, "R11 reset idle");
        run_vec(4'd15, 8'h00, 8'hFF, 4'b0101, "R11 reserved 15");
        // R1 corners
        run_vec(4'd0, 8'h0F, 8'h01, 4'b0000, "R1 half carry");
        run_vec(4'd0, 8'hFF, 8'h01, 4'b0000, "R1 wrap to zero");
        run_vec(4'd1, 8'h0E, 8'h01, 4'b0001, "R1 carry-in into nibble");
        // R2 corners
        run_vec(4'd3, 8'h00, 8'h00, 4'b0001, "R2 borrow-in underflow");
        run_vec(4'd2, 8'h10, 8'h01, 4'b0000, "R2 nibble borrow");
        // R3 equal compare
        run_vec(4'd4, 8'h42, 8'h42, 4'b0001, "R3 equal");
        run_vec(4'd5, 8'hF0, 8'h0F, 4'b0001, "R4 zero and");
        run_vec(4'd7, 8'hAA, 8'hAA, 4'b0111, "R5 xor self");
        run_vec(4'd8, 8'hFF, 8'h00, 4'b0001, "R6 inc wrap keeps C");
        run_vec(4'd9, 8'h00, 8'h00, 4'b0000, "R6 dec wrap");
        run_vec(4'd10, 8'hFF, 8'h00, 4'b0001, "R7 complement keeps Z");
        run_vec(4'd11, 8'h12, 8'h00, 4'b1110, "R8 set carry");
        run_vec(4'd12, 8'h12, 8'h00, 4'b1001, "R8 complement carry");
        // R9 corners
        run_vec(4'd13, 8'h9A, 8'h00, 4'b0000, "R9 wrap to zero");
        run_vec(4'd13, 8'h3C, 8'h00, 4'b0000, "R9 low fix");
        run_vec(4'd13, 8'h12, 8'h00, 4'b0011, "R9 flags force both");
        // R10 corners
        run_vec(4'd13, 8'hFA, 8'h00, 4'b0110, "R10 low borrow");
        run_vec(4'd13, 8'h66, 8'h00, 4'b0111, "R10 both fixes");
        // Exhaustive decimal adjust flag combinations on edge values
        for (int fv = 0; fv < 8; fv++) begin
            run_vec(4'd13, 8'h99, 8'h00, {1'b0, 3'(fv)}, "R9/R10 sweep 99");
            run_vec(4'd13, 8'hA0, 8'h00, {1'b0, 3'(fv)}, "R9/R10 sweep A0");
        end
        // Random mix over all codes
        for (int i = 0; i < 3000; i++) begin
            run_vec(4'($urandom_range(0, 15)), pick_byte(), pick_byte(), 4'($urandom), "random");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule